// File: doc/BRIEF.md
# Constant-Angle Planar Rotator with Three Multipliers

This unit turns a pair of signed fixed-point samples (a, b) through an angle fixed at build time. It returns a' = cos·a − sin·b and b' = sin·a + cos·b. One product is formed on a pre-combined operand and shared by both outputs. Each output then needs only one correction product, so the datapath has three constant multipliers rather than the four of the plain matrix form.

The three coefficients are integer parameters in signed Q2.15. A form parameter chooses between two variants. The cosine variant shares a product on the sum of the two inputs. The sine variant shares a product on their difference.

The unit has three pipeline stages and accepts one pair per clock. A valid strobe travels with each pair. There is no backpressure. Each product is rounded back to sample scale, and each final sum is clipped to the output width.

Top module: `planarRotator3m`

## Requirements
- R1: While `rstN` is low and on the first cycle after it rises, `outValid` is 0 and both `aOut` and `bOut` are 0.
- R2: A pair sampled with `inValid` high at rising edge k appears on the outputs, with `outValid` high, just after rising edge k+2. This gives a latency of three register stages. A new pair may be accepted every cycle, and `outValid` is low on every cycle that carries no such pair.
- R3: With `SINE_FORM` = 0, the shared coefficient is K_S = cos, the first correction is K_A = cos + sin and the second is K_B = sin − cos. The outputs are t = rnd((a + b)·K_S), aOut = sat(t − rnd(b·K_A)) and bOut = sat(t + rnd(a·K_B)).
- R4: With `SINE_FORM` = 1, K_S = sin, K_A = cos − sin and K_B = sin + cos. The outputs are t = rnd((a − b)·K_S), aOut = sat(t + rnd(a·K_A)) and bOut = sat(t + rnd(b·K_B)).
- R5: Coefficients are signed Q2.15 with 15 fraction bits. rnd(p) = floor((p + 2^14) / 2^15), which rounds half toward plus infinity. Each output lies within 1 LSB of the exact real value of the same expression computed with the coefficients divided by 2^15 and no rounding.
- R6: A sum above 32767 yields 32767, and a sum below −32768 yields −32768. A sum in range passes through unchanged.
- R7: On a cycle with `outValid` low, `aOut` and `bOut` keep the values of the last valid result, or 0 if there has been none since reset.
- R8: An input pair (0, 0) yields the output pair (0, 0) in both forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input pair present this cycle |
| aIn | input | 16 | First input sample, signed |
| bIn | input | 16 | Second input sample, signed |
| outValid | output | 1 | Output pair present this cycle |
| aOut | output | 16 | First rotated sample, signed |
| bOut | output | 16 | Second rotated sample, signed |

## Verification
Product rounding and output clipping can both act on the same sample. This happens when full-scale pairs push a rounded sum right to the clip edge or past it. The bench provokes this case with directed extreme pairs such as (32767, 32767), (−32768, 32767) and (1, 0). These pairs are fed back to back with ordinary samples and gaps.

Three instances are built at π/4 and π/6 in the cosine form and at π/3 in the sine form. Each result is judged against an exact integer evaluation of the rounding and clipping rules, and against the unrounded real value to within one LSB.

// File: rtl/planarRotPkg.sv
package planarRotPkg;

  // Number of register stages between input and output.
  localparam int ROT_LATENCY = 3;

  // Stage strobes that the control side hands to the datapath.
  typedef struct packed {
    logic s1En;      // capture the pre-combined operand
    logic s2En;      // capture the rounded products
    logic s3En;      // capture the clipped sums
    logic outValid;  // result register holds a fresh pair
  } rotStrobeT;

endpackage

// File: rtl/roundMul.sv
// Signed multiply by a constant coefficient, then round half-up to sample scale.
module roundMul #(
  parameter int X_W    = 16,
  parameter int COEF_W = 18,
  parameter int FRAC   = 15,
  localparam int P_W   = X_W + COEF_W,
  localparam int Y_W   = P_W - FRAC
) (
  input  logic signed [X_W-1:0]    x,
  input  logic signed [COEF_W-1:0] k,
  output logic signed [Y_W-1:0]    y
);

  localparam logic [P_W-1:0] HALF_LSB = P_W'(1) << (FRAC - 1);

  logic [P_W-1:0] xExt;
  logic [P_W-1:0] kExt;
  logic [P_W-1:0] prod;
  logic [P_W-1:0] biased;

  // The low P_W bits of the product are correct for two's complement.
  assign xExt   = {{COEF_W{x[X_W-1]}}, x};
  assign kExt   = {{X_W{k[COEF_W-1]}}, k};
  assign prod   = xExt * kExt;
  assign biased = prod + HALF_LSB;
  assign y      = biased[P_W-1:FRAC];

endmodule

// File: rtl/planarRotControl.sv
module planarRotControl
  import planarRotPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output rotStrobeT stb
);

  logic [ROT_LATENCY-1:0] vPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[ROT_LATENCY-2:0], inValid};
  end

  always_comb begin
    stb.s1En     = inValid;
    stb.s2En     = vPipe[0];
    stb.s3En     = vPipe[1];
    stb.outValid = vPipe[2];
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##2 stb.outValid);

  // R2
  idle_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ##2 !stb.outValid);

endmodule

// File: rtl/planarRotDatapath.sv
module planarRotDatapath
  import planarRotPkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 18,
  parameter int COEF_FRAC = 15,
  parameter bit SINE_FORM = 1'b0,
  parameter int K_SHARED  = 23170,
  parameter int K_CORR_A  = 46341,
  parameter int K_CORR_B  = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rotStrobeT                stb,
  input  logic signed [DATA_W-1:0] aIn,
  input  logic signed [DATA_W-1:0] bIn,
  output logic signed [DATA_W-1:0] aOut,
  output logic signed [DATA_W-1:0] bOut
);

  localparam int SUM_W   = DATA_W + 1;
  localparam int RT_W    = SUM_W + COEF_W - COEF_FRAC;
  localparam int RC_W    = DATA_W + COEF_W - COEF_FRAC;
  localparam int ACC_W   = ((RT_W > RC_W) ? RT_W : RC_W) + 1;
  localparam int N_CORR  = 2;

  localparam logic signed [COEF_W-1:0] K_S = K_SHARED[COEF_W-1:0];
  localparam logic signed [COEF_W-1:0] K_A = K_CORR_A[COEF_W-1:0];
  localparam logic signed [COEF_W-1:0] K_B = K_CORR_B[COEF_W-1:0];

  localparam logic signed [ACC_W-1:0] SAT_HI =
    {{(ACC_W - DATA_W + 1){1'b0}}, {(DATA_W - 1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO =
    {{(ACC_W - DATA_W + 1){1'b1}}, {(DATA_W - 1){1'b0}}};

  // ---------------- stage 1: pre-combine and pick correction operands
  logic signed [SUM_W-1:0]  preSumD;
  logic signed [DATA_W-1:0] corOpD [N_CORR];
  logic                     subFirst;

  logic signed [SUM_W-1:0]  s1Sum;
  logic signed [DATA_W-1:0] s1Cor [N_CORR];

  generate
    if (SINE_FORM) begin : gSineForm
      assign preSumD   = {aIn[DATA_W-1], aIn} - {bIn[DATA_W-1], bIn};
      assign corOpD[0] = aIn;
      assign corOpD[1] = bIn;
      assign subFirst  = 1'b0;
    end else begin : gCosForm
      assign preSumD   = {aIn[DATA_W-1], aIn} + {bIn[DATA_W-1], bIn};
      assign corOpD[0] = bIn;
      assign corOpD[1] = aIn;
      assign subFirst  = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Sum <= '0;
      for (int i = 0; i < N_CORR; i++) s1Cor[i] <= '0;
    end else if (stb.s1En) begin
      s1Sum <= preSumD;
      for (int i = 0; i < N_CORR; i++) s1Cor[i] <= corOpD[i];
    end
  end

  // ---------------- stage 2: three constant multipliers with rounding
  logic signed [RT_W-1:0] prodT;
  logic signed [RC_W-1:0] prodC [N_CORR];
  logic signed [RT_W-1:0] s2T;
  logic signed [RC_W-1:0] s2C [N_CORR];

  roundMul #(
    .X_W(SUM_W), .COEF_W(COEF_W), .FRAC(COEF_FRAC)
  ) sharedMul_i (
    .x(s1Sum), .k(K_S), .y(prodT)
  );

  generate
    for (genvar g = 0; g < N_CORR; g++) begin : gCorrMul
      localparam logic signed [COEF_W-1:0] K_LANE = (g == 0) ? K_A : K_B;
      roundMul #(
        .X_W(DATA_W), .COEF_W(COEF_W), .FRAC(COEF_FRAC)
      ) corrMul_i (
        .x(s1Cor[g]), .k(K_LANE), .y(prodC[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2T <= '0;
      for (int i = 0; i < N_CORR; i++) s2C[i] <= '0;
    end else if (stb.s2En) begin
      s2T <= prodT;
      for (int i = 0; i < N_CORR; i++) s2C[i] <= prodC[i];
    end
  end

  // ---------------- stage 3: final add or subtract, clip, register
  function automatic logic signed [DATA_W-1:0] clipToOut(
    input logic signed [ACC_W-1:0] v
  );
    if (v > SAT_HI)      return SAT_HI[DATA_W-1:0];
    else if (v < SAT_LO) return SAT_LO[DATA_W-1:0];
    else                 return v[DATA_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] tExt;
  logic signed [ACC_W-1:0] cExt [N_CORR];
  logic signed [ACC_W-1:0] accA;
  logic signed [ACC_W-1:0] accB;

  always_comb begin
    tExt = {{(ACC_W - RT_W){s2T[RT_W-1]}}, s2T};
    for (int i = 0; i < N_CORR; i++)
      cExt[i] = {{(ACC_W - RC_W){s2C[i][RC_W-1]}}, s2C[i]};
    accA = subFirst ? (tExt - cExt[0]) : (tExt + cExt[0]);
    accB = tExt + cExt[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aOut <= '0;
      bOut <= '0;
    end else if (stb.s3En) begin
      aOut <= clipToOut(accA);
      bOut <= clipToOut(accB);
    end
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.s3En |=> ($stable(aOut) && $stable(bOut)));

  // R8
  zero_shared_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.s2En && s1Sum == '0) |=> (s2T == '0));

endmodule

// File: rtl/planarRotator3m.sv
module planarRotator3m
  import planarRotPkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 18,
  parameter int COEF_FRAC = 15,
  parameter bit SINE_FORM = 1'b0,
  parameter int K_SHARED  = 23170,
  parameter int K_CORR_A  = 46341,
  parameter int K_CORR_B  = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] aIn,
  input  logic signed [DATA_W-1:0] bIn,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] aOut,
  output logic signed [DATA_W-1:0] bOut
);

  rotStrobeT stb;

  planarRotControl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .stb(stb)
  );

  planarRotDatapath #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
    .SINE_FORM(SINE_FORM), .K_SHARED(K_SHARED),
    .K_CORR_A(K_CORR_A), .K_CORR_B(K_CORR_B)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .aIn(aIn), .bIn(bIn), .aOut(aOut), .bOut(bOut)
  );

  assign outValid = stb.outValid;

  // R8
  zero_in_zero_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && aIn == '0 && bIn == '0) |=> ##2 (aOut == '0 && bOut == '0));

  // R2
  out_valid_known_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(outValid));

endmodule

// File: tb/planarRotator3m_tb_top.sv
module planarRotator3m_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NDUT = 3;

  // Instances: cos form at pi/4, cos form at pi/6, sine form at pi/3.
  localparam int KS [NDUT] = '{23170, 28378, 28378};
  localparam int KA [NDUT] = '{46341, 44762, -11994};
  localparam int KB [NDUT] = '{0, -11994, 44762};
  localparam bit SF [NDUT] = '{1'b0, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [15:0] aIn = '0;
  logic signed [15:0] bIn = '0;
  logic               vOut [NDUT];
  logic signed [15:0] aOut [NDUT];
  logic signed [15:0] bOut [NDUT];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  planarRotator3m #(.SINE_FORM(SF[0]), .K_SHARED(KS[0]), .K_CORR_A(KA[0]), .K_CORR_B(KB[0])) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .aIn(aIn), .bIn(bIn),
    .outValid(vOut[0]), .aOut(aOut[0]), .bOut(bOut[0]));

  planarRotator3m #(.SINE_FORM(SF[1]), .K_SHARED(KS[1]), .K_CORR_A(KA[1]), .K_CORR_B(KB[1])) dutCos30_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .aIn(aIn), .bIn(bIn),
    .outValid(vOut[1]), .aOut(aOut[1]), .bOut(bOut[1]));

  planarRotator3m #(.SINE_FORM(SF[2]), .K_SHARED(KS[2]), .K_CORR_A(KA[2]), .K_CORR_B(KB[2])) dutSin60_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .aIn(aIn), .bIn(bIn),
    .outValid(vOut[2]), .aOut(aOut[2]), .bOut(bOut[2]));

  // Expected-value model: three slots, in step with the requirement R2.
  bit             qV [3];
  longint         qA [3];
  longint         qB [3];
  longint         lastA [NDUT];
  longint         lastB [NDUT];

  function automatic longint rnd(input longint p);
    return (p + 64'sd16384) >>> 15;
  endfunction

  function automatic longint sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic real satR(input real v);
    if (v > 32767.0) return 32767.0;
    if (v < -32768.0) return -32768.0;
    return v;
  endfunction

  function automatic real absR(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic checkEq(input string tag, input int d, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s dut%0d actual %0d expected %0d", tag, d, act, exp);
    end
  endtask

  task automatic checkNear(input string tag, input int d, input longint act, input real exp);
    checks++;
    if (absR(real'(act) - exp) > 1.0) begin
      errors++;
      $display("FAIL %s dut%0d actual %0d expected %f within 1 LSB", tag, d, act, exp);
    end
  endtask

  task automatic checkOutputs();
    for (int d = 0; d < NDUT; d++) begin
      if (qV[2]) begin
        longint a = qA[2];
        longint b = qB[2];
        longint t, ea, eb, wa, wb;
        real ra, rb;
        string formTag = SF[d] ? "R4" : "R3";
        if (SF[d]) begin
          t  = rnd((a - b) * KS[d]);
          wa = t + rnd(a * KA[d]);
          wb = t + rnd(b * KB[d]);
          ra = (real'((a - b) * KS[d]) + real'(a * KA[d])) / 32768.0;
          rb = (real'((a - b) * KS[d]) + real'(b * KB[d])) / 32768.0;
        end else begin
          t  = rnd((a + b) * KS[d]);
          wa = t - rnd(b * KA[d]);
          wb = t + rnd(a * KB[d]);
          ra = (real'((a + b) * KS[d]) - real'(b * KA[d])) / 32768.0;
          rb = (real'((a + b) * KS[d]) + real'(a * KB[d])) / 32768.0;
        end
        ea = sat(wa);
        eb = sat(wb);
        checkEq("R2 outValid", d, longint'(vOut[d]), 1);
        checkEq((ea != wa) ? "R6 aOut" : (a == 0 && b == 0) ? "R8 aOut" : {formTag, " aOut"},
                d, longint'(aOut[d]), ea);
        checkEq((eb != wb) ? "R6 bOut" : (a == 0 && b == 0) ? "R8 bOut" : {formTag, " bOut"},
                d, longint'(bOut[d]), eb);
        checkNear("R5 aOut", d, longint'(aOut[d]), satR(ra));
        checkNear("R5 bOut", d, longint'(bOut[d]), satR(rb));
        lastA[d] = ea;
        lastB[d] = eb;
      end else begin
        checkEq("R2 idle outValid", d, longint'(vOut[d]), 0);
        checkEq("R7 hold aOut", d, longint'(aOut[d]), lastA[d]);
        checkEq("R7 hold bOut", d, longint'(bOut[d]), lastB[d]);
      end
    end
  endtask

  task automatic step(input bit v, input logic signed [15:0] a, input logic signed [15:0] b);
    @(negedge clk);
    checkOutputs();
    qV[2] = qV[1]; qA[2] = qA[1]; qB[2] = qB[1];
    qV[1] = qV[0]; qA[1] = qA[0]; qB[1] = qB[0];
    qV[0] = v;     qA[0] = longint'(a); qB[0] = longint'(b);
    inValid = v;
    aIn = a;
    bIn = b;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic signed [15:0] dirA [10] = '{16'sd0, 16'sd32767, -16'sd32768, 16'sd32767, -16'sd32768,
                                      16'sd1, 16'sd0, -16'sd1, 16'sd12345, 16'sd0};
    logic signed [15:0] dirB [10] = '{16'sd0, 16'sd32767, -16'sd32768, -16'sd32768, 16'sd32767,
                                      16'sd0, 16'sd1, -16'sd1, -16'sd6789, 16'sd0};
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3; i++) begin
      qV[i] = 1'b0; qA[i] = 0; qB[i] = 0;
    end
    for (int d = 0; d < NDUT; d++) begin
      lastA[d] = 0; lastB[d] = 0;
    end

    // R1: reset state, during reset and one cycle after release
    repeat (3) @(negedge clk);
    for (int d = 0; d < NDUT; d++) begin
      checkEq("R1 outValid", d, longint'(vOut[d]), 0);
      checkEq("R1 aOut", d, longint'(aOut[d]), 0);
      checkEq("R1 bOut", d, longint'(bOut[d]), 0);
    end
    rstN = 1'b1;
    @(negedge clk);
    for (int d = 0; d < NDUT; d++) begin
      checkEq("R1 outValid after release", d, longint'(vOut[d]), 0);
      checkEq("R1 aOut after release", d, longint'(aOut[d]), 0);
    end

    // Directed corners back to back (R6 full scale, R8 zero, rounding edges)
    for (int i = 0; i < 10; i++) step(1'b1, dirA[i], dirB[i]);
    repeat (4) step(1'b0, 16'sd0, 16'sd0);
    // Isolated samples separated by gaps (R2 latency, R7 hold)
    step(1'b1, 16'sd30000, 16'sd29000);
    repeat (5) step(1'b0, 16'sd777, -16'sd777);
    step(1'b1, -16'sd20000, 16'sd500);
    repeat (5) step(1'b0, 16'sd0, 16'sd0);

    // Random traffic with occasional full-scale values
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      logic [31:0] s = $urandom;
      logic signed [15:0] a = r[15:0];
      logic signed [15:0] b = r[31:16];
      if (s[3:0] == 4'd0) a = s[4] ? 16'sd32767 : -16'sd32768;
      if (s[7:4] == 4'd0) b = s[8] ? 16'sd32767 : -16'sd32768;
      step(s[10:9] != 2'b00, a, b);
    end
    repeat (5) step(1'b0, 16'sd0, 16'sd0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule